// File: doc/BRIEF.md
# Packed Dual Halfword Multiply-Accumulate Unit

This unit is a one-stage arithmetic block for signal-processing datapaths. It takes two 32-bit operands, each treated as a pair of signed 16-bit halves, plus a 64-bit accumulator input split into a low and a high word. An operation code picks one of several multiply variants:

- a single halfword product;
- a word-by-halfword product that keeps the upper part;
- a dual product sum or difference, with an optional swap of the second operand's halves;
- the upper word of a full 32x32 signed product, with optional rounding;
- an unsigned long multiply that adds two words.

Each variant either stands alone or adds to a 32-bit or 64-bit accumulator. Results and a sticky overflow flag are registered, so they appear on the clock edge after the inputs. The surrounding pipeline supplies the accumulator values and takes the results. It also clears the flag when it has consumed it.

Top module: `pmac_dual`

## Requirements
- R1: With op=0, the result is the signed product of one half of `a` and one half of `b`. Here `sel_a`=1 selects a[31:16] and `sel_a`=0 selects a[15:0], and `sel_b` selects the half of `b` in the same way.
- R2: With op=1, the result is the R1 product plus `acc_lo`, wrapped to 32 bits.
- R3: With op=2, the R1 product is sign-extended and added to the 64-bit value {`acc_hi`,`acc_lo`} modulo 2^64. The result is returned on {`res_hi`,`res_lo`}.
- R4: With op=3, the result is bits 47:16 of the signed product of `a` and the half of `b` chosen by `sel_b`. With op=4, `acc_lo` is added to that value, wrapped to 32 bits.
- R5: With op=5, the result is a[15:0]*b'[15:0] plus a[31:16]*b'[31:16], wrapped to 32 bits. If `sub`=1, the second product is subtracted from the first instead. The value b' equals `b` with its halves swapped when `sel_b`=1.
- R6: With op=6, the R5 value plus `acc_lo` is returned, wrapped to 32 bits.
- R7: With op=7, the exact R5 value is sign-extended and added to {`acc_hi`,`acc_lo`} modulo 2^64.
- R8: For ops 1, 4 and 6, `q_flag` is set when the exact sum does not fit a signed 32-bit value. The flag stays set until `q_clr` is applied. A same-cycle overflow wins over `q_clr`. No other op sets the flag, and the 64-bit forms wrap without flagging.
- R9: Ops 8, 9 and 10 return bits 63:32 of a 64-bit intermediate. For op 8 the intermediate is the signed product a*b. For op 9 it is `acc_lo`*2^32 plus a*b, and for op 10 it is `acc_lo`*2^32 minus a*b. When `rnd`=1, 2^31 is added to the intermediate first.
- R10: With op=11, the result is the unsigned a*b + `acc_lo` + `acc_hi` as a 64-bit value.
- R11: Ops 12 to 15 return zero on both result words and leave `q_flag` unchanged, apart from `q_clr`.
- R12: For ops 0, 1, 3, 4, 5, 6, 8, 9 and 10, `res_hi` is the sign extension of `res_lo`.
- R13: Results and flag update on the rising clock edge after the inputs are applied. An active-low reset clears both result words and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op | input | 4 | Operation code |
| sel_a | input | 1 | Pick upper half of `a` (halfword forms) |
| sel_b | input | 1 | Pick upper half of `b`, or swap halves in dual forms |
| sub | input | 1 | Dual forms: subtract second product |
| rnd | input | 1 | Upper-word forms: round |
| q_clr | input | 1 | Clear sticky overflow flag |
| a | input | 32 | First packed operand |
| b | input | 32 | Second packed operand |
| acc_lo | input | 32 | Accumulator low word |
| acc_hi | input | 32 | Accumulator high word |
| res_lo | output | 32 | Result low word |
| res_hi | output | 32 | Result high word |
| q_flag | output | 1 | Sticky 32-bit accumulate overflow |

## Verification
The bench builds the unit with the default half width of 16. At that width a 64-bit integer reference model holds every exact intermediate with no loss of precision. The extreme operands become reachable: -32768 squared, the 0x80000000 rounding carry, and the all-ones unsigned long product. These expose sign-extension and wrap faults at the exact bit where they occur. The flag sequence is driven through set, hold across other ops, clear, and clear against a simultaneous overflow.

// File: rtl/pmac_dual.sv
`timescale 1ns/1ps
module pmac_dual #(
  parameter int HW = 16,
  localparam int WW = 2 * HW,
  localparam int DW = 4 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          sub,
  input  logic          rnd,
  input  logic          q_clr,
  input  logic [WW-1:0] a,
  input  logic [WW-1:0] b,
  input  logic [WW-1:0] acc_lo,
  input  logic [WW-1:0] acc_hi,
  output logic [WW-1:0] res_lo,
  output logic [WW-1:0] res_hi,
  output logic          q_flag
);
  localparam int EW = WW + 3;
  localparam int XW = 3 * HW;
  localparam logic [3:0] OP_HMUL = 4'd0, OP_HMAC = 4'd1, OP_HMACL = 4'd2,
                         OP_WMUL = 4'd3, OP_WMAC = 4'd4, OP_DMUL = 4'd5,
                         OP_DMAC = 4'd6, OP_DMACL = 4'd7, OP_MMUL = 4'd8,
                         OP_MMLA = 4'd9, OP_MMLS = 4'd10, OP_UMAAL = 4'd11;

  logic signed [HW-1:0] a_l, a_h, b_l, b_h, ha, hb, bx_l, bx_h;
  assign a_l  = a[HW-1:0];
  assign a_h  = a[WW-1:HW];
  assign b_l  = b[HW-1:0];
  assign b_h  = b[WW-1:HW];
  assign ha   = sel_a ? a_h : a_l;
  assign hb   = sel_b ? b_h : b_l;
  assign bx_l = sel_b ? b_h : b_l;
  assign bx_h = sel_b ? b_l : b_h;

  logic signed [WW-1:0] hprod, p_lo, p_hi, wtop;
  logic signed [XW-1:0] wprod;
  logic signed [WW:0]   dsum;
  assign hprod = WW'(ha) * WW'(hb);
  assign p_lo  = WW'(a_l) * WW'(bx_l);
  assign p_hi  = WW'(a_h) * WW'(bx_h);
  assign dsum  = sub ? ((WW+1)'(p_lo) - (WW+1)'(p_hi))
                     : ((WW+1)'(p_lo) + (WW+1)'(p_hi));
  assign wprod = XW'($signed(a)) * XW'(hb);
  assign wtop  = WW'(wprod >>> HW);

  logic signed [DW-1:0] sprod;
  logic [DW-1:0] uprod, usum, acc64, mbase, mfin, rnd_add;
  logic signed [WW-1:0] mtop;
  assign sprod   = DW'($signed(a)) * DW'($signed(b));
  assign uprod   = DW'(a) * DW'(b);
  assign usum    = uprod + DW'(acc_lo) + DW'(acc_hi);
  assign acc64   = {acc_hi, acc_lo};
  assign rnd_add = {{WW{1'b0}}, rnd, {(WW-1){1'b0}}};

  always_comb begin
    case (op)
      OP_MMLA: mbase = {acc_lo, {WW{1'b0}}} + sprod;
      OP_MMLS: mbase = {acc_lo, {WW{1'b0}}} - sprod;
      default: mbase = sprod;
    endcase
  end
  assign mfin = mbase + rnd_add;
  assign mtop = WW'(mfin >> WW);

  logic signed [EW-1:0] term, esum;
  logic is_acc32, ovf;
  assign is_acc32 = (op == OP_HMAC) || (op == OP_WMAC) || (op == OP_DMAC);

  always_comb begin
    case (op)
      OP_HMAC: term = EW'(hprod);
      OP_WMAC: term = EW'(wtop);
      OP_DMAC: term = EW'(dsum);
      default: term = '0;
    endcase
  end
  assign esum = term + EW'($signed(acc_lo));
  assign ovf  = is_acc32 && !((&esum[EW-1:WW-1]) || !(|esum[EW-1:WW-1]));

  logic [DW-1:0] nxt;
  always_comb begin
    case (op)
      OP_HMUL:                   nxt = DW'(hprod);
      OP_HMAC, OP_WMAC, OP_DMAC: nxt = DW'($signed(esum[WW-1:0]));
      OP_HMACL:                  nxt = DW'(hprod) + acc64;
      OP_WMUL:                   nxt = DW'(wtop);
      OP_DMUL:                   nxt = DW'($signed(dsum[WW-1:0]));
      OP_DMACL:                  nxt = DW'(dsum) + acc64;
      OP_MMUL, OP_MMLA, OP_MMLS: nxt = DW'(mtop);
      OP_UMAAL:                  nxt = usum;
      default:                   nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo <= '0;
      res_hi <= '0;
      q_flag <= 1'b0;
    end else begin
      res_lo <= nxt[WW-1:0];
      res_hi <= nxt[DW-1:WW];
      q_flag <= ovf | (q_flag & ~q_clr);
    end
  end
endmodule

// File: rtl/pmac_dual_chk.sv
`timescale 1ns/1ps
module pmac_dual_chk #(
  parameter int HW = 16,
  localparam int WW = 2 * HW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    op,
  input logic          q_clr,
  input logic [WW-1:0] res_lo,
  input logic [WW-1:0] res_hi,
  input logic          q_flag
);
  logic acc32, narrow;
  assign acc32  = (op == 4'd1) || (op == 4'd4) || (op == 4'd6);
  assign narrow = (op == 4'd0) || (op == 4'd1) || (op == 4'd3) || (op == 4'd4) ||
                  (op == 4'd5) || (op == 4'd6) || (op == 4'd8) || (op == 4'd9) ||
                  (op == 4'd10);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_flag && !q_clr |=> q_flag);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_clr && !acc32 |=> !q_flag);
  p_set_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_flag) |-> $past(acc32));
  p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op >= 4'd12 |=> (res_lo == '0) && (res_hi == '0));
  p_undef_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op >= 4'd12 && !q_clr |=> $stable(q_flag));
  p_sext_r12: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |=> res_hi == {WW{res_lo[WW-1]}});
endmodule

bind pmac_dual pmac_dual_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .q_clr(q_clr),
  .res_lo(res_lo), .res_hi(res_hi), .q_flag(q_flag)
);

// File: tb/pmac_dual_test.sv
`timescale 1ns/1ps
module pmac_dual_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op = '0;
  logic sel_a = 0, sel_b = 0, sub = 0, rnd = 0, q_clr = 0;
  logic [31:0] a = '0, b = '0, acc_lo = '0, acc_hi = '0;
  logic [31:0] res_lo, res_hi;
  logic q_flag;
  int n_run = 0, n_fail = 0;
  logic exp_q = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmac_dual uut (
    .clk(clk), .rst_n(rst_n), .op(op), .sel_a(sel_a), .sel_b(sel_b), .sub(sub),
    .rnd(rnd), .q_clr(q_clr), .a(a), .b(b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .res_lo(res_lo), .res_hi(res_hi), .q_flag(q_flag)
  );

  function automatic longint sx16(input logic [15:0] v);
    return longint'($signed(v));
  endfunction
  function automatic longint sx32(input logic [31:0] v);
    return longint'($signed(v));
  endfunction

  function automatic logic [64:0] ref_model(input logic [3:0] o, input logic sa,
      input logic sb, input logic sg, input logic rd, input logic [31:0] x,
      input logic [31:0] y, input logic [31:0] al, input logic [31:0] ah);
    longint ha, hb, bl, bh, p, w, d, e, ac, m;
    logic [63:0] r, t, acc;
    logic ov;
    ha  = sa ? sx16(x[31:16]) : sx16(x[15:0]);
    hb  = sb ? sx16(y[31:16]) : sx16(y[15:0]);
    bl  = sb ? sx16(y[31:16]) : sx16(y[15:0]);
    bh  = sb ? sx16(y[15:0])  : sx16(y[31:16]);
    p   = ha * hb;
    w   = (sx32(x) * hb) >>> 16;
    d   = sg ? sx16(x[15:0]) * bl - sx16(x[31:16]) * bh
             : sx16(x[15:0]) * bl + sx16(x[31:16]) * bh;
    acc = {ah, al};
    ac  = sx32(al);
    m   = sx32(x) * sx32(y);
    e   = 0;
    ov  = 0;
    r   = '0;
    case (o)
      4'd0: r = p;
      4'd1: e = p + ac;
      4'd2: r = 64'(p) + acc;
      4'd3: r = w;
      4'd4: e = w + ac;
      4'd5: r = sx32(d[31:0]);
      4'd6: e = d + ac;
      4'd7: r = 64'(d) + acc;
      4'd8, 4'd9, 4'd10: begin
        t = 64'(m);
        if (o == 4'd9)  t = {al, 32'h0} + 64'(m);
        if (o == 4'd10) t = {al, 32'h0} - 64'(m);
        if (rd) t = t + 64'h8000_0000;
        r = sx32(t[63:32]);
      end
      4'd11: r = {32'h0, x} * {32'h0, y} + {32'h0, al} + {32'h0, ah};
      default: r = '0;
    endcase
    if (o == 4'd1 || o == 4'd4 || o == 4'd6) begin
      ov = (e > 64'sd2147483647) || (e < -64'sd2147483648);
      r  = sx32(e[31:0]);
    end
    return {ov, r};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run_op(input string tag, input logic [3:0] o, input logic sa, input logic sb,
      input logic sg, input logic rd, input logic clr, input logic [31:0] x,
      input logic [31:0] y, input logic [31:0] al, input logic [31:0] ah);
    logic [64:0] m;
    @(negedge clk);
    op = o; sel_a = sa; sel_b = sb; sub = sg; rnd = rd; q_clr = clr;
    a = x; b = y; acc_lo = al; acc_hi = ah;
    m = ref_model(o, sa, sb, sg, rd, x, y, al, ah);
    exp_q = m[64] | (exp_q & ~clr);
    @(posedge clk); #1;
    check({tag, " R12 result"}, {res_hi, res_lo}, m[63:0]);
    check({tag, " R8 flag"}, {63'h0, q_flag}, {63'h0, exp_q});
    @(negedge clk);
    q_clr = 0;
    op = 4'd12;
    exp_q = exp_q & 1'b1;
  endtask

  task automatic t_reset();
    check("R13 reset result", {res_hi, res_lo}, 64'h0);
    check("R13 reset flag", {63'h0, q_flag}, 64'h0);
  endtask

  task automatic t_latency();
    run_op("R1 prime", 4'd0, 0, 0, 0, 0, 0, 32'h0000_0003, 32'h0000_0005, 0, 0);
    @(negedge clk);
    op = 4'd0; sel_a = 0; sel_b = 0; a = 32'h0000_0007; b = 32'h0000_0009;
    #1 check("R13 before edge", {res_hi, res_lo}, 64'h0);
    @(posedge clk); #1;
    check("R13 after edge", {res_hi, res_lo}, 64'd63);
  endtask

  task automatic t_halfword();
    for (int k = 0; k < 4; k++)
      run_op("R1 select", 4'd0, k[1], k[0], 0, 0, 0, 32'h8000_7FFF, 32'h8000_FFFE, 0, 0);
    run_op("R1 min*min", 4'd0, 1, 1, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 0, 0);
  endtask

  task automatic t_hmac();
    run_op("R2 plain", 4'd1, 0, 1, 0, 0, 0, 32'h0000_0100, 32'hFFFE_0000, 32'h0000_1000, 0);
    run_op("R2 overflow", 4'd1, 1, 1, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 0);
  endtask

  task automatic t_sticky();
    run_op("R8 hold mul", 4'd0, 0, 0, 0, 0, 0, 32'h1, 32'h1, 0, 0);
    run_op("R8 hold 64 wrap", 4'd2, 0, 0, 0, 0, 0, 32'h1, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    run_op("R8 clear", 4'd0, 0, 0, 0, 0, 1, 32'h2, 32'h2, 0, 0);
    run_op("R8 no flag 64", 4'd7, 0, 0, 0, 0, 0, 32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    run_op("R8 neg overflow", 4'd1, 0, 0, 0, 0, 0, 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, 0);
    run_op("R8 clear vs set", 4'd6, 0, 0, 0, 0, 1, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 0);
    run_op("R8 clear no acc", 4'd5, 0, 0, 0, 0, 1, 32'h0001_0001, 32'h0001_0001, 0, 0);
  endtask

  task automatic t_hmacl();
    run_op("R3 neg", 4'd2, 0, 0, 0, 0, 0, 32'h0000_FFFF, 32'h0000_0001, 0, 0);
    run_op("R3 wrap", 4'd2, 0, 0, 0, 0, 0, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    run_op("R3 top", 4'd2, 1, 1, 0, 0, 0, 32'h8000_0000, 32'h7FFF_0000, 32'h0000_0010, 32'h0000_0001);
  endtask

  task automatic t_word();
    run_op("R4 bottom", 4'd3, 0, 0, 0, 0, 0, 32'h1234_5678, 32'h0000_8000, 0, 0);
    run_op("R4 top", 4'd3, 0, 1, 0, 0, 0, 32'h8000_0000, 32'h7FFF_0000, 0, 0);
    run_op("R4 acc", 4'd4, 0, 0, 0, 0, 0, 32'hFFFF_0000, 32'h0000_0003, 32'h0000_0005, 0);
    run_op("R4 acc overflow", 4'd4, 0, 1, 0, 0, 1, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 0);
  endtask

  task automatic t_dual();
    for (int k = 0; k < 4; k++)
      run_op("R5 dual", 4'd5, 0, k[1], k[0], 0, 0, 32'h0003_FFFE, 32'h0005_0007, 0, 0);
    run_op("R5 wrap", 4'd5, 0, 0, 0, 0, 0, 32'h8000_8000, 32'h8000_8000, 0, 0);
  endtask

  task automatic t_dual_acc();
    run_op("R6 acc", 4'd6, 0, 1, 1, 0, 1, 32'h0010_0020, 32'h0003_0004, 32'h0000_0100, 0);
    run_op("R6 overflow", 4'd6, 0, 0, 0, 0, 0, 32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 0);
    run_op("R7 exact", 4'd7, 0, 0, 0, 0, 1, 32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 0);
    run_op("R7 sub swap", 4'd7, 0, 1, 1, 0, 0, 32'h7FFF_8000, 32'h7FFF_7FFF, 32'h0000_0001, 32'h0000_0000);
  endtask

  task automatic t_msw();
    run_op("R9 mul", 4'd8, 0, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0);
    run_op("R9 round carry", 4'd8, 0, 0, 0, 1, 0, 32'h0001_0000, 32'h0000_8000, 0, 0);
    run_op("R9 round neg", 4'd8, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0);
    run_op("R9 add", 4'd9, 0, 0, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 32'h1234_5678, 0);
    run_op("R9 sub", 4'd10, 0, 0, 0, 1, 0, 32'h0000_0003, 32'hFFFF_FFFF, 32'h0000_0010, 0);
  endtask

  task automatic t_umaal();
    run_op("R10 max", 4'd11, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R10 mix", 4'd11, 0, 0, 0, 0, 0, 32'h8000_0001, 32'h0000_0002, 32'h0000_0005, 32'h0000_0007);
  endtask

  task automatic t_undef();
    run_op("R11 set", 4'd1, 1, 1, 0, 0, 0, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 0);
    for (int k = 12; k < 16; k++)
      run_op("R11 undefined", 4'(k), 1, 1, 1, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R11 clear", 4'd13, 0, 0, 0, 0, 1, 32'h5, 32'h5, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    op = 4'd12;
    t_latency();
    t_halfword();
    t_hmac();
    t_sticky();
    t_hmacl();
    t_word();
    t_dual();
    t_dual_acc();
    t_msw();
    t_umaal();
    t_undef();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule